// File: doc/BRIEF.md
# Dual-Width Shifted Operand Unit

This block forms the second operand of an integer ALU from a 64-bit register value. The value can pass through one of four shift kinds: logical left, logical right, arithmetic right or rotate right. The shift amount comes from a small field. A single mode input chooses between a full 64-bit operation and a 32-bit operation embedded in the 64-bit word.

In 32-bit mode the block gives exact narrow-word behaviour:
- Bits 63:32 of the source never affect the result.
- Bits 63:32 of the result are always zero.
- An arithmetic shift takes its sign from bit 31.
- A rotate wraps around bit 31.

The block has no state. The result follows the inputs within the same cycle, so the unit can sit directly in front of the ALU's B input.

There is a single right-shifting barrel datapath. A conditioning stage prepares the word for it:
- For a left shift, the word is bit-reversed, shifted right, and reversed back.
- For a 32-bit rotate, the low word is duplicated into both halves. Rotating that 64-bit pattern by less than 32 places leaves the correct 32-bit rotation in the low half.

Top module: `shifted_operand_unit`

## Requirements
- R1: The shift-kind code is decoded as 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. In 64-bit mode (`w32_i` = 0), each kind acts on all 64 bits of `src_i`, and an arithmetic right shift replicates bit 63.
- R2: In 32-bit mode, a logical left shift gives bits 31:0 equal to `src_i[31:0]` shifted left, with vacated positions filled with zero. Bits pushed past bit 31 are discarded, and `result_o[63:32]` is zero.
- R3: In 32-bit mode, a logical right shift ignores `src_i[63:32]`. Zeros enter at bit 31.
- R4: In 32-bit mode, an arithmetic right shift fills from `src_i[31]`, and `result_o[63:32]` is zero.
- R5: In 32-bit mode, a rotate right moves bits leaving bit 0 into bit 31. The 32-bit result is zero-extended to 64 bits. In either mode a rotate preserves the number of one bits in the active word.
- R6: The shift amount is taken modulo the operand width. In 32-bit mode only `shamt_i[4:0]` is used and `shamt_i[5]` has no effect. In 64-bit mode all six bits are used.
- R7: An effective shift amount of zero returns the active word unchanged. In 32-bit mode that word is `src_i[31:0]`, zero-extended.
- R8: The unit is purely combinational: `result_o` reflects the current inputs within the same cycle, with no register on the path.
- R9: Whenever `w32_i` = 1, `result_o[63:32]` is zero for every shift kind, amount and source value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 64 | Register value to be shifted |
| kind_i | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| shamt_i | input | 6 | Shift amount, reduced modulo the active width |
| w32_i | input | 1 | 1 selects 32-bit operation, 0 selects 64-bit operation |
| result_o | output | 64 | Shifted operand |

## Verification
The hardest situation to bring about is a 32-bit operation whose correct answer depends on bits crossing the word boundary. Examples are a rotate that must wrap at bit 31 rather than bit 63, a source with a dirty upper half that must not leak in, and an amount of 32 or more that must fold back into the 5-bit range. The stimulus reaches these cases with directed vectors that set `src_i[63:32]` to patterns opposite to the low word, combined with `shamt_i[5]` = 1. A long run of random source values, kinds and amounts in both modes then follows. Each result is compared against a separately written reference that operates on native 32-bit and 64-bit values.

// File: rtl/sou_pkg.sv
package sou_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  localparam int unsigned SOU_WORD_W = 64;

endpackage

// File: rtl/sou_condition.sv
module sou_condition
  import sou_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [1:0]        kind_i,
  input  logic [AMT_W-1:0]  shamt_i,
  input  logic              w32_i,
  output logic [DATA_W-1:0] prep_o,
  output logic [AMT_W-1:0]  eff_amt_o,
  output logic              go_left_o
);

  // Place the narrow word so that a wide right-shift yields narrow semantics.
  function automatic logic [DATA_W-1:0] narrow_place(input logic [HALF_W-1:0] lo,
                                                     input logic [1:0]        kind);
    logic [DATA_W-1:0] w;
    case (kind)
      SK_ROR:  w = {lo, lo};
      SK_ASR:  w = {{HALF_W{lo[HALF_W-1]}}, lo};
      default: w = {{HALF_W{1'b0}}, lo};
    endcase
    return w;
  endfunction

  // Reduce the amount modulo the active width.
  function automatic logic [AMT_W-1:0] fold_amount(input logic [AMT_W-1:0] amt,
                                                   input logic             narrow);
    return narrow ? {1'b0, amt[AMT_W-2:0]} : amt;
  endfunction

  always_comb begin
    prep_o    = w32_i ? narrow_place(src_i[HALF_W-1:0], kind_i) : src_i;
    eff_amt_o = fold_amount(shamt_i, w32_i);
    go_left_o = (kind_i == SK_LSL);
  end

endmodule

// File: rtl/sou_barrel.sv
module sou_barrel
  import sou_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] prep_i,
  input  logic [1:0]        kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              go_left_i,
  output logic [DATA_W-1:0] shifted_o
);

  function automatic logic [DATA_W-1:0] bit_reverse(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [DATA_W-1:0] stage [0:AMT_W];

  assign stage[0] = go_left_i ? bit_reverse(prep_i) : prep_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    logic [STEP-1:0] fill;
    always_comb begin
      case (kind_i)
        SK_ROR:  fill = stage[k][STEP-1:0];
        SK_ASR:  fill = {STEP{stage[k][DATA_W-1]}};
        default: fill = '0;
      endcase
    end
    assign stage[k+1] = amt_i[k] ? {fill, stage[k][DATA_W-1:STEP]} : stage[k];
  end

  assign shifted_o = go_left_i ? bit_reverse(stage[AMT_W]) : stage[AMT_W];

endmodule

// File: rtl/sou_narrow.sv
module sou_narrow #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] shifted_i,
  input  logic              w32_i,
  output logic [DATA_W-1:0] result_o
);

  function automatic logic [DATA_W-1:0] clip_upper(input logic [DATA_W-1:0] v,
                                                   input logic             narrow);
    return narrow ? {{HALF_W{1'b0}}, v[HALF_W-1:0]} : v;
  endfunction

  assign result_o = clip_upper(shifted_i, w32_i);

endmodule

// File: rtl/shifted_operand_unit.sv
module shifted_operand_unit #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [1:0]        kind_i,
  input  logic [AMT_W-1:0]  shamt_i,
  input  logic              w32_i,
  output logic [DATA_W-1:0] result_o
);

  // Named internal wires, exposed for the bound checker.
  logic [DATA_W-1:0] prep_opnd;
  logic [AMT_W-1:0]  eff_amt;
  logic              go_left;
  logic [DATA_W-1:0] shifted;

  sou_condition #(.DATA_W(DATA_W)) i_cond (
    .src_i     (src_i),
    .kind_i    (kind_i),
    .shamt_i   (shamt_i),
    .w32_i     (w32_i),
    .prep_o    (prep_opnd),
    .eff_amt_o (eff_amt),
    .go_left_o (go_left)
  );

  sou_barrel #(.DATA_W(DATA_W)) i_barrel (
    .prep_i    (prep_opnd),
    .kind_i    (kind_i),
    .amt_i     (eff_amt),
    .go_left_i (go_left),
    .shifted_o (shifted)
  );

  sou_narrow #(.DATA_W(DATA_W)) i_narrow (
    .shifted_i (shifted),
    .w32_i     (w32_i),
    .result_o  (result_o)
  );

endmodule

// File: rtl/sou_checker.sv
module sou_checker
  import sou_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned AMT_W  = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] src_i,
  input logic [1:0]        kind_i,
  input logic              w32_i,
  input logic [DATA_W-1:0] result_o,
  input logic [DATA_W-1:0] prep_opnd,
  input logic [AMT_W-1:0]  eff_amt
);

  logic [DATA_W-1:0] active_word;
  assign active_word = w32_i ? {{HALF_W{1'b0}}, src_i[HALF_W-1:0]} : src_i;

  always_comb begin
    // R9: narrow mode never produces upper-half bits
    if (w32_i)
      a_r9_upper_clear: assert (result_o[DATA_W-1:HALF_W] == '0);
    // R6: folded amount stays inside the narrow range
    if (w32_i)
      a_r6_amount_folded: assert (eff_amt[AMT_W-1] == 1'b0);
    // R7: zero amount is a pass-through of the active word
    if (eff_amt == '0)
      a_r7_zero_pass: assert (result_o == active_word);
    // R5: rotation keeps the population of the active word
    if (kind_i == SK_ROR)
      a_r5_rotate_ones: assert ($countones(result_o) == $countones(active_word));
    // R3: logical right in narrow mode sees a clean upper half
    if (w32_i && kind_i == SK_LSR)
      a_r3_clean_upper: assert (prep_opnd[DATA_W-1:HALF_W] == '0);
    // R4: narrow arithmetic right keeps the sign at bit 31
    if (w32_i && kind_i == SK_ASR)
      a_r4_sign_kept: assert (result_o[HALF_W-1] == src_i[HALF_W-1]);
    // R1: wide arithmetic right keeps the sign at bit 63
    if (!w32_i && kind_i == SK_ASR)
      a_r1_wide_sign: assert (result_o[DATA_W-1] == src_i[DATA_W-1]);
    // R2: a nonzero left shift always vacates bit 0
    if (kind_i == SK_LSL && eff_amt != '0)
      a_r2_low_vacated: assert (result_o[0] == 1'b0);
  end

endmodule

bind shifted_operand_unit sou_checker #(.DATA_W(DATA_W)) i_sou_checker (
  .src_i     (src_i),
  .kind_i    (kind_i),
  .w32_i     (w32_i),
  .result_o  (result_o),
  .prep_opnd (prep_opnd),
  .eff_amt   (eff_amt)
);

// File: tb/test_shifted_operand_unit.sv
module test_shifted_operand_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src;
  logic [1:0]  kind;
  logic [5:0]  shamt;
  logic        w32;
  logic [63:0] result;

  int n_compared   = 0;
  int n_mismatched = 0;
  bit done         = 1'b0;

  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  shifted_operand_unit i_shifted_operand_unit (
    .src_i    (src),
    .kind_i   (kind),
    .shamt_i  (shamt),
    .w32_i    (w32),
    .result_o (result)
  );

  // Independent reference on native 32/64-bit values.
  function automatic logic [63:0] model(input logic [63:0] a, input logic [1:0] k,
                                        input logic [5:0] n, input logic w);
    logic [31:0] x, y;
    logic [63:0] z;
    int m;
    if (w) begin
      x = a[31:0];
      m = int'(n[4:0]);
      case (k)
        2'd0: y = x << m;
        2'd1: y = x >> m;
        2'd2: y = $unsigned($signed(x) >>> m);
        default: y = (m == 0) ? x : ((x >> m) | (x << (32 - m)));
      endcase
      return {32'h0, y};
    end
    m = int'(n);
    case (k)
      2'd0: z = a << m;
      2'd1: z = a >> m;
      2'd2: z = $unsigned($signed(a) >>> m);
      default: z = (m == 0) ? a : ((a >> m) | (a << (64 - m)));
    endcase
    return z;
  endfunction

  task automatic drive(input logic [63:0] a, input logic [1:0] k, input logic [5:0] n,
                       input logic w, input logic [63:0] expv, input string tag);
    @(negedge clk);
    src = a; kind = k; shamt = n; w32 = w;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  task automatic drive_m(input logic [63:0] a, input logic [1:0] k, input logic [5:0] n,
                         input logic w, input string tag);
    drive(a, k, n, w, model(a, k, n, w), tag);
  endtask

  // Monitor: compares one queued expectation per cycle, after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_compared++;
        if (result !== e) begin
          n_mismatched++;
          $display("FAIL %s: src=%h kind=%0d amt=%0d w32=%0b got %h expected %h",
                   t, src, kind, shamt, w32, result, e);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_mismatched++;
      n_compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_compared, n_mismatched);
      $finish;
    end
  end

  initial begin
    src = '0; kind = 2'd0; shamt = '0; w32 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-state check: idle inputs give zero result
    drive(64'h0, 2'd0, 6'd0, 1'b0, 64'h0, "R7 idle");

    // R1: wide kinds
    drive(64'h0000_0000_0000_0001, 2'd3, 6'd1, 1'b0, 64'h8000_0000_0000_0000, "R1 ror64");
    drive(64'h8000_0000_0000_0000, 2'd2, 6'd63, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R1 asr64");
    drive(64'h8000_0000_0000_0000, 2'd1, 6'd63, 1'b0, 64'h1, "R1 lsr64");
    drive(64'h0000_0000_8000_0001, 2'd0, 6'd1, 1'b0, 64'h0000_0001_0000_0002, "R1 lsl64");
    // R2: narrow left drops carry past bit 31
    drive(64'hFFFF_FFFF_8000_0001, 2'd0, 6'd1, 1'b1, 64'h2, "R2 lsl32");
    // R3: narrow logical right ignores dirty upper half
    drive(64'hFFFF_FFFF_8000_0000, 2'd1, 6'd4, 1'b1, 64'h0800_0000, "R3 lsr32");
    // R4: narrow arithmetic right from bit 31
    drive(64'h0000_0000_8000_0000, 2'd2, 6'd4, 1'b1, 64'hF800_0000, "R4 asr32");
    drive(64'hFFFF_FFFF_7000_0000, 2'd2, 6'd4, 1'b1, 64'h0700_0000, "R4 asr32 pos");
    // R5: narrow rotate wraps at bit 31
    drive(64'hFFFF_FFFF_0000_0001, 2'd3, 6'd1, 1'b1, 64'h8000_0000, "R5 ror32");
    drive(64'h0000_0000_1234_5678, 2'd3, 6'd8, 1'b1, 64'h7812_3456, "R5 ror32 byte");
    // R6: amount folding
    drive(64'h1, 2'd0, 6'd33, 1'b1, 64'h2, "R6 fold lsl");
    drive(64'h0000_0000_1234_5678, 2'd3, 6'd40, 1'b1, 64'h7812_3456, "R6 fold ror");
    drive(64'h1, 2'd0, 6'd33, 1'b0, 64'h2_0000_0000, "R6 wide uses bit5");
    // R7: zero amount pass-through
    drive(64'hDEAD_BEEF_1234_5678, 2'd2, 6'd32, 1'b1, 64'h1234_5678, "R7 zero32");
    drive(64'hDEAD_BEEF_1234_5678, 2'd3, 6'd0, 1'b0, 64'hDEAD_BEEF_1234_5678, "R7 zero64");
    // R9: every kind clears upper half in narrow mode
    for (int k = 0; k < 4; k++)
      drive_m(64'hFFFF_FFFF_FFFF_FFFF, k[1:0], 6'd5, 1'b1, "R9 upper");

    // R8: each new input combination is checked in the same cycle it is applied
    for (int i = 0; i < 600; i++) begin
      logic [63:0] a;
      a = {$urandom(), $urandom()};
      drive_m(a, 2'($urandom()), 6'($urandom()), 1'($urandom()), "R8 random");
    end

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_compared, n_mismatched);
    $finish;
  end

endmodule